// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block is a serial transmit and receive engine whose character format is set by a six-bit control register. The register picks the number of data bits, whether a parity bit is added and with which polarity, the number of stop bits, and a multiprocessor mode. In that mode an address/data marker bit takes the place of parity. A write strobe hands one byte to the transmitter, which sends it least significant bit first. The receiver oversamples the incoming line, rebuilds each character, checks parity and the stop bit, and presents the byte, the marker bit and two error flags with a single-cycle valid pulse.

Bit timing comes from an external enable, `os_tick`, that pulses sixteen times per bit period. A second operating mode turns the engine into a plain 8-bit clocked shift path. The transmitter shifts eight bits out and drives a shift clock. The receiver captures the incoming line on each rising shift-clock edge, so one transfer moves a byte in each direction.

Top module: `async_frame_engine`

## Requirements
- R1: After reset every control bit is 0, which gives asynchronous mode, 8 data bits, no parity, even polarity, 1 stop bit and multiprocessor mode off. `txd` idles at 1, `tx_busy` is 0 and `sclk` is 1. A `cfg_wr` pulse loads `cfg_wdata`, laid out as [0] synchronous mode, [1] 7-bit characters, [2] parity enable, [3] odd parity, [4] two stop bits, [5] multiprocessor mode.
- R2: A `tx_wr` pulse while idle raises `tx_busy` and drives the start bit (0) on `txd` in the next cycle. The data follows least significant bit first. Each bit lasts 16 `os_tick` pulses, and `tx_busy` stays high until the last stop bit ends. A `tx_wr` pulse while busy is ignored.
- R3: In 7-bit mode only data bits 0 to 6 are sent, and bit 7 of the received byte reads 0.
- R4: With parity enabled, the transmitter appends a parity bit after the data. With even polarity the data bits and the parity bit together hold an even number of ones; with odd polarity they hold an odd number. The receiver raises `rx_par_err` when the received parity does not match.
- R5: The transmitter sends 1 stop bit, or 2 when the two-stop-bit control is set. The receiver checks only the first stop bit, and a 0 in the second stop position is taken as the start bit of the next character.
- R6: In multiprocessor mode one extra bit, taken from `tx_mpb`, follows the data. The receiver reports it on `rx_mpb`. Parity is neither added nor checked, whatever the parity enable and polarity bits say.
- R7: The receiver detects a start bit on a falling edge of the line and confirms it 8 oversample ticks later. If the line is high again at that point, it returns to idle and reports nothing.
- R8: `rx_frm_err` is set when the first stop bit samples 0. Both error flags, the data and the marker bit are valid in the cycle of the one-cycle `rx_valid` pulse.
- R9: In synchronous mode exactly 8 bits are shifted, with no start, stop, parity or marker bit, whatever the character-length bit says. `sclk` is low for the first half and high for the second half of each bit, and the receiver captures the line on each rising `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control register write value |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_mpb | input | 1 | Marker bit sent in multiprocessor mode |
| tx_busy | output | 1 | Transmitter is sending a character |
| txd | output | 1 | Serial transmit line |
| sclk | output | 1 | Shift clock in synchronous mode, 1 otherwise |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Received marker bit |
| rx_par_err | output | 1 | Parity mismatch on the reported character |
| rx_frm_err | output | 1 | First stop bit sampled as 0 |

## Verification
Several faults show up at the ports within one character time. A wrong frame builder or bit counter shows on the looped-back byte, the marker bit or the length of the `tx_busy` window when the character ends. A receiver that drifts off mid-bit, counts the wrong number of data bits, or checks the second stop bit reports a different byte or a wrong error flag. It may also drop the character that follows without a gap. A start qualifier that does not return to idle produces an extra `rx_valid` pulse, which the scoreboard catches as an unexpected item.

// File: rtl/afe_pkg.sv
// Shared types and helpers for the serial frame engine.
// Assumes the control register layout given in the brief (sync mode at bit 0).
package afe_pkg;

    typedef struct packed {
        logic mp;       // [5] multiprocessor marker instead of parity
        logic stop2;    // [4] two stop bits on transmit
        logic par_odd;  // [3] odd parity polarity
        logic par_en;   // [2] parity enable
        logic len7;     // [1] 7-bit characters
        logic sync;     // [0] clocked synchronous shift mode
    } afe_cfg_t;

    localparam int CFG_W = $bits(afe_cfg_t);

    // Parity bit for the given data and polarity (even: XOR of data).
    function automatic logic par_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/afe_ctrl_reg.sv
// Frame format control register.
// Loads the whole register on a write strobe and resets to all zeros.
module afe_ctrl_reg
    import afe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CFG_W-1:0]     wdata,
    output afe_cfg_t             cfg
);

    afe_cfg_t cfg_q;

    // Holds the format bits; cleared by reset, replaced on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (wr) cfg_q <= afe_cfg_t'(wdata);
    end

    assign cfg = cfg_q;

    // R1
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));

endmodule

// File: rtl/afe_tx.sv
// Transmit serializer.
// Builds the whole frame when a byte is accepted and shifts it out LSB first,
// one bit per OS_RATE oversample ticks. In sync mode it sends 8 bare bits,
// drives the shift clock and issues mid-bit sample strobes for the receiver.
// Assumes the control register stays steady while a character is in flight.
module afe_tx
    import afe_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int FRAME_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  afe_cfg_t   cfg,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       mpb,
    output logic       txd,
    output logic       busy,
    output logic       sclk,
    output logic       smp_stb,
    output logic       smp_last
);

    localparam int CW   = $clog2(OS_RATE);
    localparam int NW   = $clog2(FRAME_W + 1);
    localparam int HALF = OS_RATE / 2;

    logic [FRAME_W-1:0] frame_q, frame_d;
    logic [NW-1:0]      left_q, nbits_d;
    logic [CW-1:0]      tick_q;
    logic               busy_q, sync_q;
    logic [3:0]         nd;
    logic               extra, xbit;
    logic [7:0]         dmask;

    // Frame builder: start, data, optional parity or marker, stop bits.
    always_comb begin
        nd      = cfg.sync ? 4'd8 : (cfg.len7 ? 4'd7 : 4'd8);
        dmask   = (cfg.len7 && !cfg.sync) ? {1'b0, data[6:0]} : data;
        extra   = !cfg.sync && (cfg.mp || cfg.par_en);
        xbit    = cfg.mp ? mpb : par_bit(dmask, cfg.par_odd);
        frame_d = '1;
        if (cfg.sync) begin
            frame_d[7:0] = data;
            nbits_d      = NW'(8);
        end else begin
            frame_d[0] = 1'b0;
            for (int i = 0; i < 8; i++)
                if (i < int'(nd)) frame_d[i+1] = data[i];
            if (extra) frame_d[nd+4'd1] = xbit;
            nbits_d = NW'(1) + NW'(nd) + NW'(extra) + (cfg.stop2 ? NW'(2) : NW'(1));
        end
    end

    // Accepts a byte when idle, then shifts one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
            left_q  <= '0;
            tick_q  <= '0;
            busy_q  <= 1'b0;
            sync_q  <= 1'b0;
        end else if (!busy_q) begin
            if (wr) begin
                frame_q <= frame_d;
                left_q  <= nbits_d;
                tick_q  <= '0;
                busy_q  <= 1'b1;
                sync_q  <= cfg.sync;
            end
        end else if (os_tick) begin
            if (tick_q == CW'(OS_RATE - 1)) begin
                tick_q  <= '0;
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                left_q  <= left_q - NW'(1);
                if (left_q == NW'(1)) busy_q <= 1'b0;
            end else begin
                tick_q <= tick_q + CW'(1);
            end
        end
    end

    assign txd      = busy_q ? frame_q[0] : 1'b1;
    assign busy     = busy_q;
    assign sclk     = !(busy_q && sync_q) || (tick_q >= CW'(HALF));
    assign smp_stb  = busy_q && sync_q && os_tick && (tick_q == CW'(HALF - 1));
    assign smp_last = smp_stb && (left_q == NW'(1));

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_q) && !sync_q) |-> !txd);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(left_q) == NW'(1)));

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> sclk);

endmodule

// File: rtl/afe_rx.sv
// Receive deserializer.
// Async mode: synchronizes the line, finds a falling edge, confirms the start
// bit half a bit later, then samples every bit at its centre. Only the first
// stop bit is examined. Sync mode: shifts the line on strobes from the
// transmitter and reports after 8 bits.
// Assumes the control register stays steady while a character is in flight.
module afe_rx
    import afe_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  afe_cfg_t   cfg,
    input  logic       rxd,
    input  logic       smp_stb,
    input  logic       smp_last,
    output logic       valid,
    output logic [7:0] data,
    output logic       mpb,
    output logic       par_err,
    output logic       frm_err
);

    localparam int CW   = $clog2(OS_RATE);
    localparam int HALF = OS_RATE / 2;

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP} rx_state_t;

    rx_state_t  st_q;
    logic       s1_q, s2_q, prev_q;
    logic [CW-1:0] cnt_q;
    logic [3:0] left_q;
    logic [7:0] sh_q;
    logic       x_q;
    afe_cfg_t   fmt_q;
    logic [7:0] dbits;
    logic       mid;

    // Two-stage synchronizer and per-tick line history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
            if (os_tick) prev_q <= s2_q;
        end
    end

    assign dbits = fmt_q.len7 ? {1'b0, sh_q[7:1]} : sh_q;
    assign mid   = os_tick && (cnt_q == CW'(OS_RATE - 1));

    // Character state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
            sh_q    <= '0;
            x_q     <= 1'b0;
            fmt_q   <= '0;
            valid   <= 1'b0;
            data    <= '0;
            mpb     <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (cfg.sync) begin
                st_q <= RX_IDLE;
                if (smp_stb) begin
                    sh_q <= {s2_q, sh_q[7:1]};
                    if (smp_last) begin
                        valid   <= 1'b1;
                        data    <= {s2_q, sh_q[7:1]};
                        mpb     <= 1'b0;
                        par_err <= 1'b0;
                        frm_err <= 1'b0;
                    end
                end
            end else begin
                case (st_q)
                    RX_IDLE: if (os_tick && prev_q && !s2_q) begin
                        st_q  <= RX_START;
                        cnt_q <= '0;
                    end
                    RX_START: if (os_tick) begin
                        if (cnt_q == CW'(HALF - 1)) begin
                            cnt_q  <= '0;
                            st_q   <= s2_q ? RX_IDLE : RX_DATA;
                            fmt_q  <= cfg;
                            left_q <= cfg.len7 ? 4'd7 : 4'd8;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    RX_DATA: if (mid) begin
                        cnt_q  <= '0;
                        sh_q   <= {s2_q, sh_q[7:1]};
                        left_q <= left_q - 4'd1;
                        if (left_q == 4'd1)
                            st_q <= (fmt_q.mp || fmt_q.par_en) ? RX_EXTRA : RX_STOP;
                    end else if (os_tick) cnt_q <= cnt_q + CW'(1);
                    RX_EXTRA: if (mid) begin
                        cnt_q <= '0;
                        x_q   <= s2_q;
                        st_q  <= RX_STOP;
                    end else if (os_tick) cnt_q <= cnt_q + CW'(1);
                    RX_STOP: if (mid) begin
                        cnt_q   <= '0;
                        st_q    <= RX_IDLE;
                        valid   <= 1'b1;
                        data    <= dbits;
                        mpb     <= fmt_q.mp ? x_q : 1'b0;
                        par_err <= !fmt_q.mp && fmt_q.par_en &&
                                   (par_bit(dbits, fmt_q.par_odd) != x_q);
                        frm_err <= !s2_q;
                    end else if (os_tick) cnt_q <= cnt_q + CW'(1);
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    mp_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && fmt_q.mp && !cfg.sync) |-> !par_err);

    // R3
    len7_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && fmt_q.len7 && !cfg.sync) |-> !data[7]);

endmodule

// File: rtl/async_frame_engine.sv
// Top level of the configurable serial frame engine.
// Ties the control register, transmitter and receiver together; the
// receiver borrows the transmitter's bit timing in synchronous mode.
module async_frame_engine
    import afe_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       cfg_wr,
    input  logic [5:0] cfg_wdata,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       tx_mpb,
    output logic       tx_busy,
    output logic       txd,
    output logic       sclk,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_mpb,
    output logic       rx_par_err,
    output logic       rx_frm_err
);

    afe_cfg_t cfg;
    logic     smp_stb, smp_last;

    afe_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    afe_tx #(.OS_RATE(OS_RATE)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .cfg      (cfg),
        .wr       (tx_wr),
        .data     (tx_data),
        .mpb      (tx_mpb),
        .txd      (txd),
        .busy     (tx_busy),
        .sclk     (sclk),
        .smp_stb  (smp_stb),
        .smp_last (smp_last)
    );

    afe_rx #(.OS_RATE(OS_RATE)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .cfg      (cfg),
        .rxd      (rxd),
        .smp_stb  (smp_stb),
        .smp_last (smp_last),
        .valid    (rx_valid),
        .data     (rx_data),
        .mpb      (rx_mpb),
        .par_err  (rx_par_err),
        .frm_err  (rx_frm_err)
    );

endmodule

// File: tb/tb_async_frame_engine.sv
// Scoreboard bench: stimulus tasks queue expected characters, a monitor
// compares each rx_valid result against the queue head.
module tb_async_frame_engine;

    localparam int BITCLK = 32;   // 16 ticks, one tick every 2 clocks

    typedef struct packed {
        logic [7:0] d;
        logic       m;
        logic       pe;
        logic       fe;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
    logic cfg_wr = 1'b0, tx_wr = 1'b0, tx_mpb = 1'b0;
    logic [5:0] cfg_wdata = '0, cfg_sh = '0;
    logic [7:0] tx_data = '0;
    logic tx_busy, txd, sclk, rx_valid, rx_mpb, rx_par_err, rx_frm_err;
    logic [7:0] rx_data;
    logic loop = 1'b1, drv = 1'b1;
    logic rxd;
    int   n_chk = 0, n_bad = 0, cyc = 0;
    item_t q[$];

    assign rxd = loop ? txd : drv;

    async_frame_engine dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_mpb(tx_mpb),
        .tx_busy(tx_busy), .txd(txd), .sclk(sclk), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_mpb(rx_mpb),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always #10 clk = ~clk;

    // Oversample enable every second clock; cycle counter for the watchdog.
    always @(posedge clk) begin
        os_tick <= ~os_tick;
        cyc     <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare on each reported character.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R7 unexpected character", int'(rx_data), 0);
            end else begin
                item_t e, a;
                e = q.pop_front();
                a = '{rx_data, rx_mpb, rx_par_err, rx_frm_err};
                check(a == e, "R2/R3/R4/R6/R8 rx item", int'(a), int'(e));
            end
        end
    end

    task automatic set_cfg(input logic [5:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0; cfg_sh = v;
    endtask

    // Transmit one byte through the loopback; optionally poke a write while busy.
    task automatic send(input logic [7:0] d, input logic m, input bit poke, input string req);
        item_t e;
        int nb, nd, len;
        bit saw_low;
        logic [7:0] dm;
        nd = cfg_sh[0] ? 8 : (cfg_sh[1] ? 7 : 8);
        dm = (cfg_sh[1] && !cfg_sh[0]) ? {1'b0, d[6:0]} : d;
        nb = cfg_sh[0] ? 8 : 1 + nd + ((cfg_sh[5] || cfg_sh[2]) ? 1 : 0) + (cfg_sh[4] ? 2 : 1);
        e  = '{dm, (cfg_sh[5] && !cfg_sh[0]) ? m : 1'b0, 1'b0, 1'b0};
        q.push_back(e);
        @(negedge clk); tx_wr = 1'b1; tx_data = d; tx_mpb = m;
        @(negedge clk); tx_wr = 1'b0;
        check(tx_busy == 1'b1, "R2 busy after write", int'(tx_busy), 1);
        if (!cfg_sh[0]) check(txd == 1'b0, "R2 start bit", int'(txd), 0);
        len = 1; saw_low = 1'b0;
        while (tx_busy) begin
            if (poke && len == 100) begin
                tx_wr = 1'b1; tx_data = ~d; tx_mpb = ~m;
            end else tx_wr = 1'b0;
            if (!sclk) saw_low = 1'b1;
            @(negedge clk); len++;
        end
        tx_wr = 1'b0;
        check((len >= nb*BITCLK - 2) && (len <= nb*BITCLK + 2), {req, " busy length"}, len, nb*BITCLK);
        check(saw_low == cfg_sh[0], "R9 sclk activity", int'(saw_low), int'(cfg_sh[0]));
        repeat (3*BITCLK) @(negedge clk);
    endtask

    // Drive a raw frame on the receive line, LSB first.
    task automatic drive(input logic [11:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            drv = bits[i];
            repeat (BITCLK) @(negedge clk);
        end
        drv = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        check(tx_busy == 1'b0, "R1 busy idle", int'(tx_busy), 0);
        check(sclk == 1'b1, "R1 sclk idle", int'(sclk), 1);
        check(rx_valid == 1'b0, "R1 no valid", int'(rx_valid), 0);
        // R1 defaults give 8N1: ten bits
        send(8'hA5, 1'b0, 1'b0, "R1");
        // R2 write while busy is ignored
        send(8'h3C, 1'b0, 1'b1, "R2");
        check(q.size() == 0, "R2 single character", q.size(), 0);
        // R3 seven data bits
        set_cfg(6'b000010);
        send(8'hFF, 1'b0, 1'b0, "R3");
        send(8'h80, 1'b0, 1'b0, "R3");
        // R4 even and odd parity, 8 and 7 bits
        set_cfg(6'b000100);
        send(8'h03, 1'b0, 1'b0, "R4");
        send(8'h07, 1'b0, 1'b0, "R4");
        set_cfg(6'b001100);
        send(8'h03, 1'b0, 1'b0, "R4");
        set_cfg(6'b001110);
        send(8'h55, 1'b0, 1'b0, "R4");
        // R4 bad parity: 8E1, data 03 needs parity 0, send 1
        set_cfg(6'b000100);
        loop = 1'b0;
        q.push_back('{8'h03, 1'b0, 1'b1, 1'b0});
        drive({1'b1, 1'b1, 8'h03, 1'b0}, 11);
        repeat (2*BITCLK) @(negedge clk);
        check(q.size() == 0, "R4 parity error reported", q.size(), 0);
        // R5 two stop bits on transmit
        set_cfg(6'b010000);
        loop = 1'b1;
        send(8'h81, 1'b0, 1'b0, "R5");
        // R5 second stop 0 starts the next character
        loop = 1'b0;
        q.push_back('{8'h12, 1'b0, 1'b0, 1'b0});
        q.push_back('{8'hE7, 1'b0, 1'b0, 1'b0});
        drive({2'b11, 8'h12, 1'b0}, 10);
        drive({2'b11, 8'hE7, 1'b0}, 10);
        repeat (3*BITCLK) @(negedge clk);
        check(q.size() == 0, "R5 back-to-back received", q.size(), 0);
        // R6 marker bit, parity settings ignored
        set_cfg(6'b101100);
        loop = 1'b1;
        send(8'h03, 1'b1, 1'b0, "R6");
        send(8'hF0, 1'b0, 1'b0, "R6");
        // R7 short glitch is not a start bit
        set_cfg(6'b000000);
        loop = 1'b0;
        drv = 1'b0;
        repeat (8) @(negedge clk);
        drv = 1'b1;
        repeat (3*BITCLK) @(negedge clk);
        check(q.size() == 0, "R7 glitch rejected", q.size(), 0);
        q.push_back('{8'h6B, 1'b0, 1'b0, 1'b0});
        drive({2'b11, 8'h6B, 1'b0}, 10);
        repeat (2*BITCLK) @(negedge clk);
        // R8 framing error on first stop bit
        q.push_back('{8'h5A, 1'b0, 1'b0, 1'b1});
        drive({2'b00, 8'h5A, 1'b0}, 10);
        repeat (3*BITCLK) @(negedge clk);
        check(q.size() == 0, "R8 framing error reported", q.size(), 0);
        // R9 synchronous shift, 7-bit select ignored
        set_cfg(6'b000011);
        loop = 1'b1;
        send(8'hA5, 1'b0, 1'b0, "R9");
        send(8'h81, 1'b0, 1'b0, "R9");
        check(q.size() == 0, "R9 all characters seen", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000) begin
            check(1'b0, "watchdog timeout", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule